// File: doc/BRIEF.md
# ATA Task-File Register Bridge

This block holds the standard ATA task-file registers and exposes them to two owners: an external host on a parallel IDE-style port, and a local control processor on a small memory-mapped port. The processor runs the drive. It decides on busy and data-request status and answers commands. The host sees an ordinary ATA register set. When the host writes the command register, the processor is interrupted. When a sector transfer finishes, the processor is interrupted again.

A 512-byte sector buffer sits behind the host data register and is used for both PIO and DMA transfers. The host moves 16-bit words, low byte at the even address. The processor reads and writes the buffer a byte at a time. A storage reader can also stream bytes straight into the buffer with no processor involvement. That fill stream is valid/ready. While the host data phase is open (DRQ set), `f_ready` is low and the source must hold `f_valid` and `f_data`. Otherwise `f_ready` is high, and every cycle with `f_valid` high stores one byte at the next sequential address.

All host strobes are synchronous to `clk` and last one cycle per access. Read data on both ports is combinational from the address and select inputs.

Top module: `ata_taskfile_bridge`

## Requirements
- R1: Host offsets 2..6 of the command block (sector count, LBA low, LBA mid, LBA high, device) are written by the host and read by the processor at register indices 2..6. The processor writes the error register (index 1), which the host reads at command-block offset 1. Processor writes to indices 2..6 are also visible to the host.
- R2: A host write to command-block offset 7 while BSY (status bit 7) is 0 stores the byte as the command (processor index 7), sets interrupt flag bit 0 (processor index 10), and raises `p_irq`.
- R3: While BSY is 1, host writes to the command register (offset 7) and feature register (offset 1) are ignored and raise no interrupt.
- R4: While DRQ (status bit 3) is 1, a host read of data offset 0 returns `{buf[ptr+1], buf[ptr]}` and advances `ptr` by 2. A processor write to the status register (index 8) that sets DRQ from 0 resets `ptr` to 0.
- R5: The data access that uses bytes 510/511 clears DRQ, sets interrupt flag bit 1, and raises `p_irq`.
- R6: While DRQ is 1, host writes to data offset 0 store the word little-endian at `ptr`. While DRQ is 0, they change nothing.
- R7: A processor write to control index 11 with bit 1 set makes a host interrupt pending. `h_intrq` shows the pending request unless device-control bit 1 (control block offset 6) is set. A host read of status (offset 7) clears the pending request; a read of alternate status (control block offset 6) does not.
- R8: Writing ones to processor index 10 clears the matching interrupt flags, and `p_irq` falls when none remain.
- R9: `f_ready` equals not-DRQ. Each accepted fill byte goes to the next address, starting at 0 after reset and wrapping after 511. The processor reads buffer byte `a` at `p_addr = 512 + a`.
- R10: When a fill byte is accepted in the same cycle as a processor buffer write, the fill byte is stored, the processor write is dropped, and `p_busy` is high in that cycle. Without a collision, processor buffer writes are stored and `p_busy` stays low.
- R11: With control index 11 bit 0 set, `dma_req` equals DRQ. A host read with `dma_ack` high acts as a data-register read without any chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_cs_cmd | input | 1 | Host select, command block |
| h_cs_ctl | input | 1 | Host select, control block |
| h_addr | input | 3 | Host register offset |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_intrq | output | 1 | Host interrupt request |
| dma_req | output | 1 | DMA request to host |
| dma_ack | input | 1 | DMA acknowledge, selects the data register |
| p_addr | input | 10 | Processor address; top bit selects the buffer |
| p_wr | input | 1 | Processor write strobe |
| p_wdata | input | 8 | Processor write data |
| p_rdata | output | 8 | Processor read data |
| p_busy | output | 1 | Processor buffer write lost to another writer |
| p_irq | output | 1 | Processor interrupt |
| f_valid | input | 1 | Fill byte valid |
| f_ready | output | 1 | Fill byte accepted when valid |
| f_data | input | 8 | Fill byte |

## Verification
The hardest condition to reach is a fill byte and a processor buffer write landing on the same clock edge. The fill port is only ready outside a host data phase, and its address is hidden. To reach it, the bench first streams exactly 512 bytes so the fill address wraps to 0. It then raises `f_valid` and a processor write to a different byte in the same cycle. It checks that byte 0 holds the fill data and that the targeted byte kept its old value. The completion edge is reached by a full 256-word host read, with DRQ checked one word before the end.

// File: rtl/ata_bridge_pkg.sv
package ata_bridge_pkg;
  localparam int ST_BSY = 7;
  localparam int ST_DRQ = 3;

  localparam logic [3:0] PR_FEAT   = 4'd0;
  localparam logic [3:0] PR_ERR    = 4'd1;
  localparam logic [3:0] PR_CMD    = 4'd7;
  localparam logic [3:0] PR_STAT   = 4'd8;
  localparam logic [3:0] PR_DEVCTL = 4'd9;
  localparam logic [3:0] PR_IRQ    = 4'd10;
  localparam logic [3:0] PR_CTL    = 4'd11;

  typedef struct packed {
    logic       blk_cmd;
    logic       blk_ctl;
    logic       data_sel;
    logic       data_rd;
    logic       data_wr;
    logic       cmd_wr;
    logic       feat_wr;
    logic       tf_wr;
    logic       stat_rd;
    logic       devctl_wr;
    logic [2:0] idx;
  } host_op_t;
endpackage

// File: rtl/ata_host_decode.sv
module ata_host_decode
  import ata_bridge_pkg::*;
(
  input  logic       cs_cmd,
  input  logic       cs_ctl,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic       dma_ack,
  output host_op_t   op
);
  always_comb begin
    op          = '0;
    op.idx      = addr;
    op.blk_cmd  = cs_cmd & ~dma_ack;
    op.blk_ctl  = cs_ctl & ~cs_cmd & ~dma_ack;
    op.data_sel = dma_ack | (op.blk_cmd & (addr == 3'd0));
    op.data_rd  = op.data_sel & rd;
    op.data_wr  = op.data_sel & wr;
    if (op.blk_cmd) begin
      op.cmd_wr  = wr & (addr == 3'd7);
      op.feat_wr = wr & (addr == 3'd1);
      op.tf_wr   = wr & (addr >= 3'd2) & (addr <= 3'd6);
      op.stat_rd = rd & (addr == 3'd7);
    end
    if (op.blk_ctl) op.devctl_wr = wr & (addr == 3'd6);
  end
endmodule

// File: rtl/ata_sector_buffer.sv
module ata_sector_buffer #(
  parameter int BYTES = 512,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_we,
  input  logic [7:0]    fill_data,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  input  logic          proc_we,
  input  logic [AW-1:0] proc_addr,
  input  logic [7:0]    proc_wdata,
  output logic [7:0]    proc_rdata,
  output logic          proc_busy
);
  logic [7:0]    mem [BYTES];
  logic [AW-1:0] fptr;
  logic [AW-1:0] host_lo, host_hi;
  logic          proc_we_eff;

  assign host_lo     = {host_addr[AW-1:1], 1'b0};
  assign host_hi     = {host_addr[AW-1:1], 1'b1};
  assign proc_busy   = proc_we & (fill_we | host_we);
  assign proc_we_eff = proc_we & ~proc_busy;
  assign host_rdata  = {mem[host_hi], mem[host_lo]};
  assign proc_rdata  = mem[proc_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) fptr <= '0;
    else if (fill_we) fptr <= fptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) mem[fptr] <= fill_data;
    if (host_we) begin
      mem[host_lo] <= host_wdata[7:0];
      mem[host_hi] <= host_wdata[15:8];
    end
    if (proc_we_eff) mem[proc_addr] <= proc_wdata;
  end

  // R9: an accepted fill byte is stored at the fill address
  a_r9_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> mem[$past(fptr)] == $past(fill_data));

  // R10: a colliding processor write leaves its byte untouched
  a_r10_fill_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && proc_we && !host_we && proc_addr != fptr)
      |=> mem[$past(proc_addr)] == $past(mem[proc_addr]));
endmodule

// File: rtl/ata_task_regs.sv
module ata_task_regs
  import ata_bridge_pkg::*;
#(
  parameter int BYTES = 512,
  localparam int AW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  host_op_t      op,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_reg_rdata,
  input  logic          p_we,
  input  logic [3:0]    p_idx,
  input  logic [7:0]    p_wdata,
  output logic [7:0]    p_reg_rdata,
  output logic [AW-1:0] hptr,
  output logic          drq,
  output logic          dma_mode,
  output logic          h_intrq,
  output logic          p_irq
);
  localparam logic [AW-1:0] LAST = AW'(BYTES - 2);

  logic [7:0] status_q, feat_q, cmd_q, err_q, devctl_q;
  logic [7:0] tf_q [8];
  logic [1:0] irq_q;
  logic       h_pend;
  logic       stat_wr, ctl_wr, irq_wr, xfer, last_xfer, cmd_take, ctl_set;

  assign drq       = status_q[ST_DRQ];
  assign stat_wr   = p_we & (p_idx == PR_STAT);
  assign ctl_wr    = p_we & (p_idx == PR_CTL);
  assign irq_wr    = p_we & (p_idx == PR_IRQ);
  assign ctl_set   = ctl_wr & p_wdata[1];
  assign xfer      = (op.data_rd | op.data_wr) & drq;
  assign last_xfer = xfer & (hptr == LAST);
  assign cmd_take  = op.cmd_wr & ~status_q[ST_BSY];
  assign h_intrq   = h_pend & ~devctl_q[1];
  assign p_irq     = |irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      hptr     <= '0;
    end else begin
      if (stat_wr) status_q <= p_wdata;
      else if (last_xfer) status_q[ST_DRQ] <= 1'b0;
      if (stat_wr && p_wdata[ST_DRQ] && !drq) hptr <= '0;
      else if (xfer) hptr <= hptr + AW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q   <= '0;
      cmd_q    <= '0;
      err_q    <= '0;
      devctl_q <= '0;
      dma_mode <= 1'b0;
      h_pend   <= 1'b0;
      irq_q    <= '0;
      for (int i = 0; i < 8; i++) tf_q[i] <= '0;
    end else begin
      if (op.feat_wr && !status_q[ST_BSY]) feat_q <= h_wdata;
      if (cmd_take) cmd_q <= h_wdata;
      if (op.devctl_wr) devctl_q <= h_wdata;
      if (op.tf_wr) tf_q[op.idx] <= h_wdata;
      else if (p_we && p_idx >= 4'd2 && p_idx <= 4'd6) tf_q[p_idx[2:0]] <= p_wdata;
      if (p_we && p_idx == PR_ERR) err_q <= p_wdata;
      if (ctl_wr) dma_mode <= p_wdata[0];
      if (ctl_set) h_pend <= 1'b1;
      else if (op.stat_rd) h_pend <= 1'b0;
      irq_q <= (irq_q & ~(irq_wr ? p_wdata[1:0] : 2'b00)) | {last_xfer, cmd_take};
    end
  end

  always_comb begin
    h_reg_rdata = '0;
    if (op.blk_cmd) begin
      case (op.idx)
        3'd1:    h_reg_rdata = err_q;
        3'd7:    h_reg_rdata = status_q;
        3'd0:    h_reg_rdata = '0;
        default: h_reg_rdata = tf_q[op.idx];
      endcase
    end else if (op.blk_ctl && op.idx == 3'd6) begin
      h_reg_rdata = status_q;
    end
  end

  always_comb begin
    case (p_idx)
      PR_FEAT:   p_reg_rdata = feat_q;
      PR_ERR:    p_reg_rdata = err_q;
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6: p_reg_rdata = tf_q[p_idx[2:0]];
      PR_CMD:    p_reg_rdata = cmd_q;
      PR_STAT:   p_reg_rdata = status_q;
      PR_DEVCTL: p_reg_rdata = devctl_q;
      PR_IRQ:    p_reg_rdata = {6'b0, irq_q};
      PR_CTL:    p_reg_rdata = {6'b0, h_pend, dma_mode};
      default:   p_reg_rdata = '0;
    endcase
  end

  // R2: an accepted command write raises the command flag
  a_r2_cmd_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> irq_q[0]);

  // R3: BSY blocks command and feature writes
  a_r3_bsy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (op.cmd_wr && status_q[ST_BSY]) |=> $stable(cmd_q));
  a_r3_bsy_blocks_feat: assert property (@(posedge clk) disable iff (!rst_n)
    (op.feat_wr && status_q[ST_BSY]) |=> $stable(feat_q));

  // R4: each data access steps the pointer by one word
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !stat_wr) |=> hptr == $past(hptr) + AW'(2));

  // R5: the final word closes the data phase
  a_r5_done: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && !stat_wr) |=> (!drq && irq_q[1]));

  // R7: a status read clears the pending host request
  a_r7_intrq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op.stat_rd && !ctl_set) |=> !h_pend);
endmodule

// File: rtl/ata_taskfile_bridge.sv
module ata_taskfile_bridge
  import ata_bridge_pkg::*;
#(
  parameter int BYTES = 512,
  localparam int AW = $clog2(BYTES),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_cs_cmd,
  input  logic          h_cs_ctl,
  input  logic [2:0]    h_addr,
  input  logic          h_rd,
  input  logic          h_wr,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  output logic          h_intrq,
  output logic          dma_req,
  input  logic          dma_ack,
  input  logic [PW-1:0] p_addr,
  input  logic          p_wr,
  input  logic [7:0]    p_wdata,
  output logic [7:0]    p_rdata,
  output logic          p_busy,
  output logic          p_irq,
  input  logic          f_valid,
  output logic          f_ready,
  input  logic [7:0]    f_data
);
  host_op_t      op;
  logic [7:0]    h_reg_rdata, p_reg_rdata, p_buf_rdata;
  logic [15:0]   h_buf_rdata;
  logic [AW-1:0] hptr;
  logic          drq, dma_mode, fill_we, host_we, p_buf_sel;

  assign p_buf_sel = p_addr[PW-1];
  assign f_ready   = ~drq;
  assign fill_we   = f_valid & f_ready;
  assign host_we   = op.data_wr & drq;
  assign dma_req   = dma_mode & drq;
  assign h_rdata   = op.data_sel ? h_buf_rdata : {8'h00, h_reg_rdata};
  assign p_rdata   = p_buf_sel ? p_buf_rdata : p_reg_rdata;

  ata_host_decode u_decode (
    .cs_cmd (h_cs_cmd),
    .cs_ctl (h_cs_ctl),
    .addr   (h_addr),
    .rd     (h_rd),
    .wr     (h_wr),
    .dma_ack(dma_ack),
    .op     (op)
  );

  ata_task_regs #(.BYTES(BYTES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .h_wdata    (h_wdata[7:0]),
    .h_reg_rdata(h_reg_rdata),
    .p_we       (p_wr & ~p_buf_sel),
    .p_idx      (p_addr[3:0]),
    .p_wdata    (p_wdata),
    .p_reg_rdata(p_reg_rdata),
    .hptr       (hptr),
    .drq        (drq),
    .dma_mode   (dma_mode),
    .h_intrq    (h_intrq),
    .p_irq      (p_irq)
  );

  ata_sector_buffer #(.BYTES(BYTES)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_we   (fill_we),
    .fill_data (f_data),
    .host_we   (host_we),
    .host_addr (hptr),
    .host_wdata(h_wdata),
    .host_rdata(h_buf_rdata),
    .proc_we   (p_wr & p_buf_sel),
    .proc_addr (p_addr[AW-1:0]),
    .proc_wdata(p_wdata),
    .proc_rdata(p_buf_rdata),
    .proc_busy (p_busy)
  );

  // R11: DMA request follows DRQ in DMA mode
  a_r11_dma_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && drq) |-> dma_req);
endmodule

// File: tb/ata_taskfile_bridge_tb.sv
`timescale 1ns/1ps
module ata_taskfile_bridge_tb;
  logic clk = 0, rst_n = 0;
  logic h_cs_cmd = 0, h_cs_ctl = 0, h_rd = 0, h_wr = 0, dma_ack = 0;
  logic [2:0] h_addr = 0;
  logic [15:0] h_wdata = 0, h_rdata;
  logic h_intrq, dma_req, p_busy, p_irq, f_ready;
  logic [9:0] p_addr = 0;
  logic p_wr = 0;
  logic [7:0] p_wdata = 0, p_rdata;
  logic f_valid = 0;
  logic [7:0] f_data = 0;

  logic [7:0] exp_buf [512];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ata_taskfile_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .h_cs_cmd(h_cs_cmd), .h_cs_ctl(h_cs_ctl),
    .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_intrq(h_intrq), .dma_req(dma_req), .dma_ack(dma_ack),
    .p_addr(p_addr), .p_wr(p_wr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_busy(p_busy), .p_irq(p_irq), .f_valid(f_valid), .f_ready(f_ready),
    .f_data(f_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic host_wr(input bit ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    h_cs_cmd = ~ctl; h_cs_ctl = ctl; h_addr = a; h_wdata = d; h_wr = 1;
    @(posedge clk); #1;
    h_cs_cmd = 0; h_cs_ctl = 0; h_wr = 0;
  endtask

  task automatic host_rd(input bit ctl, input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    h_cs_cmd = ~ctl; h_cs_ctl = ctl; h_addr = a; h_rd = 1;
    #1 d = h_rdata;
    @(posedge clk); #1;
    h_cs_cmd = 0; h_cs_ctl = 0; h_rd = 0;
  endtask

  task automatic dma_rd(output logic [15:0] d);
    @(negedge clk);
    dma_ack = 1; h_rd = 1;
    #1 d = h_rdata;
    @(posedge clk); #1;
    dma_ack = 0; h_rd = 0;
  endtask

  task automatic proc_wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    p_addr = a; p_wdata = d; p_wr = 1;
    @(posedge clk); #1;
    p_wr = 0;
  endtask

  task automatic proc_rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    p_addr = a;
    #1 d = p_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report();
  end

  initial begin
    logic [15:0] hw;
    logic [7:0] pb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // reset state
    chk(h_intrq == 0 && p_irq == 0 && dma_req == 0, "reset irq/dma", {h_intrq, p_irq, dma_req}, 0);
    chk(f_ready == 1, "R9 reset f_ready", f_ready, 1);
    proc_rd(10'd8, pb); chk(pb == 8'h00, "reset status", pb, 0);

    // R9: fill 512 bytes with gaps
    for (int i = 0; i < 512; i++) begin
      exp_buf[i] = 8'((i * 37 + 11) & 255);
      @(negedge clk);
      f_valid = 1; f_data = exp_buf[i];
      @(posedge clk); #1 f_valid = 0;
      if (i % 5 == 4) @(posedge clk);
    end
    for (int i = 0; i < 512; i++) begin
      proc_rd(10'd512 + 10'(i), pb);
      chk(pb == exp_buf[i], "R9 fill contents", pb, exp_buf[i]);
    end

    // R4/R5: full PIO read
    proc_wr(10'd8, 8'h48);
    chk(f_ready == 0, "R9 f_ready low in DRQ", f_ready, 0);
    for (int w = 0; w < 256; w++) begin
      if (w == 255) begin
        proc_rd(10'd8, pb);
        chk(pb[3] == 1 && p_irq == 0, "R5 DRQ held before last", {pb, 7'b0, p_irq}, 16'h4800);
      end
      host_rd(0, 3'd0, hw);
      chk(hw == {exp_buf[2*w+1], exp_buf[2*w]}, "R4 host word", hw, {exp_buf[2*w+1], exp_buf[2*w]});
    end
    host_rd(1, 3'd6, hw);
    chk(hw[3] == 0, "R5 DRQ cleared", hw, 16'h40);
    proc_rd(10'd10, pb);
    chk(pb == 8'h02 && p_irq == 1, "R5 done flag", pb, 2);

    // R8: acknowledge
    proc_wr(10'd10, 8'h02);
    chk(p_irq == 0, "R8 ack clears p_irq", p_irq, 0);

    // R1: taskfile visibility
    for (int a = 2; a <= 6; a++) host_wr(0, 3'(a), 16'(8'h10 * a + 5));
    for (int a = 2; a <= 6; a++) begin
      proc_rd(10'(a), pb);
      chk(pb == 8'(8'h10 * a + 5), "R1 host->proc taskfile", pb, 8'h10 * a + 5);
    end
    proc_wr(10'd1, 8'h04);
    host_rd(0, 3'd1, hw); chk(hw == 16'h0004, "R1 error reg", hw, 4);
    proc_wr(10'd3, 8'hA1);
    host_rd(0, 3'd3, hw); chk(hw == 16'h00A1, "R1 proc->host lba", hw, 16'hA1);

    // R2: command interrupt
    proc_wr(10'd8, 8'h40);
    host_wr(0, 3'd1, 16'h0033);
    host_wr(0, 3'd7, 16'h00EC);
    proc_rd(10'd7, pb); chk(pb == 8'hEC, "R2 command stored", pb, 8'hEC);
    proc_rd(10'd10, pb); chk(pb == 8'h01 && p_irq, "R2 cmd flag", pb, 1);
    proc_rd(10'd0, pb); chk(pb == 8'h33, "R2 feature stored", pb, 8'h33);
    proc_wr(10'd10, 8'h01);
    chk(p_irq == 0, "R8 cmd ack", p_irq, 0);

    // R3: BSY blocks
    proc_wr(10'd8, 8'h80);
    host_wr(0, 3'd7, 16'h0020);
    host_wr(0, 3'd1, 16'h0055);
    proc_rd(10'd7, pb); chk(pb == 8'hEC, "R3 command ignored", pb, 8'hEC);
    proc_rd(10'd0, pb); chk(pb == 8'h33, "R3 feature ignored", pb, 8'h33);
    chk(p_irq == 0, "R3 no irq", p_irq, 0);
    proc_wr(10'd8, 8'h40);

    // R7: host interrupt
    proc_wr(10'd11, 8'h02);
    chk(h_intrq == 1, "R7 set", h_intrq, 1);
    host_rd(1, 3'd6, hw); chk(h_intrq == 1, "R7 alt status keeps", h_intrq, 1);
    host_wr(1, 3'd6, 16'h0002); chk(h_intrq == 0, "R7 nIEN masks", h_intrq, 0);
    host_wr(1, 3'd6, 16'h0000); chk(h_intrq == 1, "R7 unmask pending", h_intrq, 1);
    host_rd(0, 3'd7, hw); chk(h_intrq == 0, "R7 status read clears", h_intrq, 0);

    // R6: host writes
    host_wr(0, 3'd0, 16'hFFFF);
    proc_rd(10'd512, pb); chk(pb == exp_buf[0], "R6 write ignored without DRQ", pb, exp_buf[0]);
    proc_wr(10'd8, 8'h48);
    for (int w = 0; w < 256; w++) begin
      hw = 16'((w * 16'h0305) ^ 16'h5A3C);
      exp_buf[2*w] = hw[7:0]; exp_buf[2*w+1] = hw[15:8];
      host_wr(0, 3'd0, hw);
    end
    for (int i = 0; i < 512; i += 7) begin
      proc_rd(10'd512 + 10'(i), pb);
      chk(pb == exp_buf[i], "R6 host write contents", pb, exp_buf[i]);
    end
    chk(f_ready == 1 && p_irq == 1, "R5 write phase done", {f_ready, p_irq}, 3);
    proc_wr(10'd10, 8'h03);

    // R10: collision (fill address has wrapped to 0)
    @(negedge clk);
    f_valid = 1; f_data = 8'hC3; p_wr = 1; p_addr = 10'd517; p_wdata = 8'h77;
    #1 chk(p_busy == 1, "R10 busy on collision", p_busy, 1);
    @(posedge clk); #1 f_valid = 0; p_wr = 0;
    exp_buf[0] = 8'hC3;
    proc_rd(10'd512, pb); chk(pb == 8'hC3, "R10 fill stored", pb, 8'hC3);
    proc_rd(10'd517, pb); chk(pb == exp_buf[5], "R10 proc write dropped", pb, exp_buf[5]);
    @(negedge clk); p_wr = 1; p_addr = 10'd518; p_wdata = 8'h99;
    #1 chk(p_busy == 0, "R10 no busy alone", p_busy, 0);
    @(posedge clk); #1 p_wr = 0;
    exp_buf[6] = 8'h99;
    proc_rd(10'd518, pb); chk(pb == 8'h99, "R10 proc write stored", pb, 8'h99);

    // R11: DMA read
    proc_wr(10'd11, 8'h01);
    chk(dma_req == 0, "R11 no req without DRQ", dma_req, 0);
    proc_wr(10'd8, 8'h48);
    chk(dma_req == 1, "R11 req with DRQ", dma_req, 1);
    for (int w = 0; w < 256; w++) begin
      dma_rd(hw);
      chk(hw == {exp_buf[2*w+1], exp_buf[2*w]}, "R11 dma word", hw, {exp_buf[2*w+1], exp_buf[2*w]});
    end
    chk(dma_req == 0 && p_irq == 1, "R11 dma done", {dma_req, p_irq}, 1);

    report();
  end
endmodule